// File: doc/BRIEF.md
# Flit Packet Framer with Class-Dependent Lengths

This block sits on one receive link that delivers one 39-bit flit per clock: a 32-bit payload word and a 7-bit check field, which the block carries alongside unchanged. It finds where packets begin and end. There is no free length field. The first flit of each packet holds a 3-bit class code and a one-bit length variant, and together they pick one length from a small legal set that depends on the class. The framer then numbers every flit of the packet. It marks the first flit, the header flits and the last flit. Every flit after the header is a payload flit.

The link uses a valid/ready handshake and passes straight through. Downstream readiness is returned to the sender unchanged, and a flit moves only when valid and ready are both high. If a first flit names a class and variant pair that selects no legal length, the framer drops that flit and pulses an error strobe. It then takes the next accepted flit as a fresh header. Downstream logic uses the class tag, the flit index and the header indication to steer header flits and data flits to their consumers.

Top module: `flit_framer`

## Requirements
- R1: After reset the framer is idle. The first accepted flit is taken as a header: out_sop=1, out_index=0, out_hdr=1. out_err is low whenever in_valid is low.
- R2: The class is the 3-bit field in payload bits [2:0] of the first flit, and the variant is payload bit 3. For class codes 0, 1 and 2 with variant 0, the packet is 3 flits long and every flit is a header flit. out_class holds the code for the whole packet.
- R3: Class 3 is 2 flits long with variant 0 and 3 flits long with variant 1. All of its flits are header flits.
- R4: Class 4 is 18 flits long with variant 0, made of 2 header flits and then 16 data flits. With variant 1 it is 19 flits long, made of 3 header flits and then 16 data flits.
- R5: Class 5 with variant 0 is 19 flits long: 3 header flits and then 16 data flits.
- R6: Class 6 is 1 flit long with variant 0, and that flit has out_sop and out_eop high together. With variant 1 it is 3 header flits.
- R7: An illegal pair is class 7, or class 0, 1, 2 or 5 with variant 1. When such a first flit is accepted, out_err pulses for that cycle and out_valid stays low. The next accepted flit is decoded as a new header. Flits after the first flit of a packet are never decoded for class, even when their low bits match an illegal pair.
- R8: in_ready equals out_ready. When in_valid or out_ready is low, the flit index and the packet state do not advance.
- R9: out_payload equals in_flit[31:0], and out_check equals in_flit[38:32].
- R10: out_index counts 0 to length-1 over the accepted flits of a packet. out_eop is high on index length-1 only, and out_valid equals in_valid for every flit of a legal packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sender has a flit |
| in_flit | input | 39 | Flit: check bits [38:32], payload [31:0] |
| in_ready | output | 1 | Framer accepts the flit (equals out_ready) |
| out_valid | output | 1 | Annotated flit is presented |
| out_ready | input | 1 | Downstream accepts the flit |
| out_payload | output | 32 | Payload word |
| out_check | output | 7 | Check bits, unchanged |
| out_class | output | 3 | Class code of the current packet |
| out_index | output | 5 | Position of the flit in its packet |
| out_sop | output | 1 | First flit of a packet |
| out_hdr | output | 1 | Flit is a header flit |
| out_eop | output | 1 | Last flit of a packet |
| out_err | output | 1 | Illegal first flit was dropped this cycle |

## Verification
The bench builds the block with its default parameters: 32 payload bits, 7 check bits and 16 data flits. With these values every legal length (1, 2, 3, 18 and 19) and both header sizes of the long packets can be reached. The behavioural model is compared with the design on every clock. The stimulus covers back-to-back packets, gaps in valid, stretches with ready low in the middle of long packets, all three kinds of illegal pair, and data flits whose low bits look like an illegal header.

// File: rtl/flitfrm_pkg.sv
package flitfrm_pkg;
    typedef enum logic [2:0] {
        CLS_REQ   = 3'd0,
        CLS_FWD   = 3'd1,
        CLS_RDIO  = 3'd2,
        CLS_NBRSP = 3'd3,
        CLS_BLRSP = 3'd4,
        CLS_WRIO  = 3'd5,
        CLS_SPCL  = 3'd6,
        CLS_RSVD  = 3'd7
    } pkt_class_e;

    localparam int unsigned CLS_W     = 3;
    localparam int unsigned SHORT_HDR = 2;
    localparam int unsigned LONG_HDR  = 3;
endpackage

// File: rtl/flitfrm_class_dec.sv
module flitfrm_class_dec
    import flitfrm_pkg::*;
#(
    parameter int unsigned DATA_FLITS = 16,
    parameter int unsigned IDX_W      = 5
) (
    input  logic [CLS_W-1:0] cls_i,
    input  logic             var_i,
    output logic             legal_o,
    output logic [IDX_W-1:0] len_o,
    output logic [IDX_W-1:0] hdr_o
);
    localparam int unsigned LEN_SHORT_BLK = DATA_FLITS + SHORT_HDR;
    localparam int unsigned LEN_LONG_BLK  = DATA_FLITS + LONG_HDR;

    always_comb begin
        legal_o = 1'b1;
        len_o   = IDX_W'(3);
        hdr_o   = IDX_W'(3);
        case (pkt_class_e'(cls_i))
            CLS_REQ, CLS_FWD, CLS_RDIO: begin
                legal_o = !var_i;
            end
            CLS_NBRSP: begin
                len_o = var_i ? IDX_W'(3) : IDX_W'(2);
                hdr_o = len_o;
            end
            CLS_BLRSP: begin
                len_o = var_i ? IDX_W'(LEN_LONG_BLK) : IDX_W'(LEN_SHORT_BLK);
                hdr_o = var_i ? IDX_W'(LONG_HDR) : IDX_W'(SHORT_HDR);
            end
            CLS_WRIO: begin
                legal_o = !var_i;
                len_o   = IDX_W'(LEN_LONG_BLK);
                hdr_o   = IDX_W'(LONG_HDR);
            end
            CLS_SPCL: begin
                len_o = var_i ? IDX_W'(3) : IDX_W'(1);
                hdr_o = len_o;
            end
            default: begin
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flitfrm_seq.sv
module flitfrm_seq
    import flitfrm_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [CLS_W-1:0] hdr_cls,
    input  logic             dec_legal,
    input  logic [IDX_W-1:0] dec_len,
    input  logic [IDX_W-1:0] dec_hdr,
    output logic             out_valid,
    output logic [CLS_W-1:0] out_class,
    output logic [IDX_W-1:0] out_index,
    output logic             out_sop,
    output logic             out_hdr,
    output logic             out_eop,
    output logic             out_err
);
    typedef struct packed {
        logic             busy;
        logic [CLS_W-1:0] cls;
        logic [IDX_W-1:0] len;
        logic [IDX_W-1:0] hdr;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;
    logic fire;

    assign fire = in_valid && out_ready;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            out_class = hdr_cls;
            out_index = '0;
            out_sop   = dec_legal;
            out_hdr   = 1'b1;
            out_eop   = dec_legal && (dec_len == IDX_W'(1));
            out_valid = in_valid && dec_legal;
            out_err   = fire && !dec_legal;
            if (fire && dec_legal && (dec_len != IDX_W'(1))) begin
                st_d.busy = 1'b1;
                st_d.cls  = hdr_cls;
                st_d.len  = dec_len;
                st_d.hdr  = dec_hdr;
                st_d.idx  = IDX_W'(1);
            end
        end else begin
            out_class = st_q.cls;
            out_index = st_q.idx;
            out_sop   = 1'b0;
            out_hdr   = st_q.idx < st_q.hdr;
            out_eop   = st_q.idx == (st_q.len - IDX_W'(1));
            out_valid = in_valid;
            out_err   = 1'b0;
            if (fire) begin
                if (out_eop) begin
                    st_d.busy = 1'b0;
                    st_d.idx  = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.idx < st_q.len) && (st_q.idx != '0));

    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fire) |=> ($stable(st_q.idx) && st_q.busy));

    // R10
    eop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_eop && out_valid) |=> !st_q.busy);

    // R7
    err_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (!out_valid && !st_q.busy));

    // R7
    err_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |=> !st_q.busy);
endmodule

// File: rtl/flit_framer.sv
module flit_framer
    import flitfrm_pkg::*;
#(
    parameter int unsigned PAY_W      = 32,
    parameter int unsigned CHK_W      = 7,
    parameter int unsigned DATA_FLITS = 16,
    localparam int unsigned FLIT_W    = PAY_W + CHK_W,
    localparam int unsigned IDX_W     = $clog2(DATA_FLITS + LONG_HDR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAY_W-1:0]  out_payload,
    output logic [CHK_W-1:0]  out_check,
    output logic [CLS_W-1:0]  out_class,
    output logic [IDX_W-1:0]  out_index,
    output logic              out_sop,
    output logic              out_hdr,
    output logic              out_eop,
    output logic              out_err
);
    logic             dec_legal;
    logic [IDX_W-1:0] dec_len;
    logic [IDX_W-1:0] dec_hdr;

    assign in_ready    = out_ready;
    assign out_payload = in_flit[PAY_W-1:0];
    assign out_check   = in_flit[FLIT_W-1:PAY_W];

    flitfrm_class_dec #(
        .DATA_FLITS(DATA_FLITS),
        .IDX_W     (IDX_W)
    ) dec_i (
        .cls_i  (in_flit[CLS_W-1:0]),
        .var_i  (in_flit[CLS_W]),
        .legal_o(dec_legal),
        .len_o  (dec_len),
        .hdr_o  (dec_hdr)
    );

    flitfrm_seq #(
        .IDX_W(IDX_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .hdr_cls  (in_flit[CLS_W-1:0]),
        .dec_legal(dec_legal),
        .dec_len  (dec_len),
        .dec_hdr  (dec_hdr),
        .out_valid(out_valid),
        .out_class(out_class),
        .out_index(out_index),
        .out_sop  (out_sop),
        .out_hdr  (out_hdr),
        .out_eop  (out_eop),
        .out_err  (out_err)
    );

    // R1
    sop_is_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_hdr && (out_index == '0)));

    // R8
    ready_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);

    // R7
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (in_valid && out_ready));
endmodule

// File: tb/flit_framer_tb.sv
module flit_framer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [38:0] in_flit = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_payload;
    logic [6:0]  out_check;
    logic [2:0]  out_class;
    logic [4:0]  out_index;
    logic        out_sop, out_hdr, out_eop, out_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";
    int stall_mode = 0;
    int cyc = 0;

    // behavioural model state
    bit m_busy = 0;
    int m_len = 0, m_hdr = 0, m_idx = 0, m_cls = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flit_framer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_payload(out_payload), .out_check(out_check), .out_class(out_class),
        .out_index(out_index), .out_sop(out_sop), .out_hdr(out_hdr),
        .out_eop(out_eop), .out_err(out_err)
    );

    function automatic int legal_len(int c, int v);
        case (c)
            0, 1, 2: return v ? 0 : 3;
            3:       return v ? 3 : 2;
            4:       return v ? 19 : 18;
            5:       return v ? 0 : 19;
            6:       return v ? 3 : 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int l, c, v;
            bit e_valid, e_sop, e_hdr, e_eop, e_err, fire;
            int e_idx, e_cls;
            cyc++;
            fire = in_valid && out_ready;
            c = int'(in_flit[2:0]);
            v = int'(in_flit[3]);
            l = legal_len(c, v);
            if (!m_busy) begin
                e_valid = in_valid && (l != 0);
                e_err = fire && (l == 0);
                e_sop = 1; e_hdr = 1; e_idx = 0; e_cls = c; e_eop = (l == 1);
            end else begin
                e_valid = in_valid; e_err = 0; e_sop = 0;
                e_idx = m_idx; e_cls = m_cls;
                e_hdr = (m_idx < m_hdr); e_eop = (m_idx == m_len - 1);
            end
            chk("in_ready (R8)", in_ready, out_ready);
            chk("out_valid (R10)", out_valid, e_valid);
            chk("out_err (R7)", out_err, e_err);
            chk("out_payload (R9)", out_payload, in_flit[31:0]);
            chk("out_check (R9)", out_check, in_flit[38:32]);
            if (e_valid) begin
                chk("out_sop", out_sop, e_sop);
                chk("out_hdr", out_hdr, e_hdr);
                chk("out_index", out_index, e_idx);
                chk("out_eop", out_eop, e_eop);
                chk("out_class", out_class, e_cls);
            end
            if (fire) begin
                if (!m_busy) begin
                    if (l > 1) begin
                        m_busy = 1; m_len = l; m_idx = 1; m_cls = c;
                        m_hdr = (l >= 18) ? l - 16 : l;
                    end
                end else if (m_idx == m_len - 1) begin
                    m_busy = 0; m_idx = 0;
                end else begin
                    m_idx++;
                end
            end
        end
    end

    // downstream readiness pattern
    always @(posedge clk) begin
        #1;
        if (stall_mode == 0) out_ready = 1'b1;
        else out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 4);
    end

    task automatic put_flit(logic [31:0] pay, logic [6:0] ck, bit gap);
        if (gap) begin
            in_valid = 1'b0;
            in_flit = {7'h55, 32'hFFFF_FFFF};
            @(posedge clk); #2;
        end
        in_valid = 1'b1;
        in_flit = {ck, pay};
        do begin
            @(posedge clk);
        end while (!(in_ready && in_valid));
        #2;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(int c, int v, int n, int seed, bit gaps);
        for (int i = 0; i < n; i++) begin
            logic [31:0] p;
            p = 32'hA5C3_0000 ^ (seed * 32'h0101_0107) ^ (i << 8);
            if (i == 0) p = {p[31:4], v[0], c[2:0]};
            else if (i % 3 == 1) p = {p[31:4], 4'hF};   // looks like class 7
            put_flit(p, 7'(seed + i), gaps && (i % 4 == 2));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        cur_req = "R1";
        chk("reset out_valid R1", out_valid, 0);
        chk("reset out_err R1", out_err, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        cur_req = "R1";  send_pkt(0, 0, 3, 1, 0);
        cur_req = "R2";  send_pkt(1, 0, 3, 2, 0); send_pkt(2, 0, 3, 3, 1);
        cur_req = "R3";  send_pkt(3, 0, 2, 4, 0); send_pkt(3, 1, 3, 5, 1);
        cur_req = "R4";  send_pkt(4, 0, 18, 6, 0); send_pkt(4, 1, 19, 7, 1);
        cur_req = "R5";  send_pkt(5, 0, 19, 8, 0);
        cur_req = "R6";  send_pkt(6, 0, 1, 9, 0); send_pkt(6, 0, 1, 10, 0);
        send_pkt(6, 1, 3, 11, 0);
        cur_req = "R7";  send_pkt(7, 0, 1, 12, 0); send_pkt(5, 1, 1, 13, 0);
        send_pkt(0, 1, 1, 14, 1); send_pkt(4, 1, 19, 15, 0);
        cur_req = "R8";  stall_mode = 1;
        send_pkt(4, 0, 18, 16, 1); send_pkt(3, 0, 2, 17, 0);
        send_pkt(7, 1, 1, 18, 0); send_pkt(6, 0, 1, 19, 1);
        send_pkt(5, 0, 19, 20, 1);
        cur_req = "R9";  stall_mode = 0; send_pkt(2, 0, 3, 21, 0);
        cur_req = "R10"; send_pkt(4, 1, 19, 22, 0); send_pkt(1, 0, 3, 23, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule